// File: doc/BRIEF.md
# Registered-DIMM SDRAM Timing Adjuster

This block sits between the command sequencer of an SDRAM controller and the output pins. Every sequencer signal passes through one baseline register. Four static configuration bits can each add one more clock to a separate group of signals. This lets one controller drive either unbuffered modules or modules with a register on the command and address path.

The four groups are read capture, the data-path mux control, the write-data window and the command/address group. The command/address group covers the chip selects for up to six banks, both copies of the row strobe, column strobe and write enable, the odd and even copies of address bit 0, address bits 1 to 13, the two bank bits, one mux clock enable and the mux output enable. Every signal in that group moves together, so the signals keep their alignment with each other. The read adjustment delays the point where read data is taken from the data bus, and the read-valid strobe follows that point. The write hold keeps each write word on the bus for one extra clock.

The configuration bits may change only while the sequencer is idle. A change during an active access gives undefined timing for that access. When write hold is set, the sequencer leaves at least one idle cycle between write words.

Top module: `rdimm_retimer`

## Requirements
- R1: A synchronous reset with rst_n low sets all outputs to their inactive levels one clock later. These are all active-low strobes, chip selects, clock enables and the output enable high, mux select low, pin_wdrv low and rd_valid low.
- R2: With a group's configuration bit clear, each output of that group equals the sequencer input sampled at the previous rising edge (one register of latency).
- R3: With cfg_cmd_adj set, every command/address output equals the sequencer input from two rising edges earlier. That covers chip selects, strobes, address, bank, pin_mux_ckea_n and pin_mux_oe_n, and all of these stay aligned with each other.
- R4: With cfg_mux_adj set, pin_mux_sel, pin_mux_cke1_n and pin_mux_cke2_n equal the sequencer inputs from two rising edges earlier.
- R5: Read data is captured from dq_in at the rising edge where seq_rd_cap is high, or one edge later when cfg_rd_adj is set. rd_valid rises one clock after the capture edge, with rd_data holding the captured word.
- R6: With cfg_wr_hold set, a word presented with seq_wvalid drives pin_wdrv high and pin_wdata to that word for two consecutive cycles, starting one clock after it is presented.
- R7: With cfg_wr_hold clear, pin_wdrv equals seq_wvalid one clock earlier, and pin_wdata carries the word presented with it.
- R8: Each configuration bit changes only the timing of its own group. All sixteen settings give the per-group latencies of R2 to R7 at the same time.
- R9: Index 0 and index 1 of pin_ras_n, pin_cas_n and pin_we_n are always equal. pin_addr0_odd always equals pin_addr0_even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SDRAM clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_rd_adj | input | 1 | Add one clock to the read capture point |
| cfg_mux_adj | input | 1 | Add one clock to mux select and its two clock enables |
| cfg_wr_hold | input | 1 | Hold each write word one extra clock |
| cfg_cmd_adj | input | 1 | Add one clock to the command/address group |
| seq_cs_n | input | NUM_CS | Chip selects, active low |
| seq_ras_n | input | 1 | Row strobe, active low |
| seq_cas_n | input | 1 | Column strobe, active low |
| seq_we_n | input | 1 | Write enable, active low |
| seq_addr | input | ADDR_W | Row/column address |
| seq_ba | input | BANK_W | Internal bank address |
| seq_mux_ckea_n | input | 1 | Mux clock enable in the command group, active low |
| seq_mux_oe_n | input | 1 | Mux output enable, active low |
| seq_mux_sel | input | 1 | Data-path mux select |
| seq_mux_cke1_n | input | 1 | First mux clock enable, active low |
| seq_mux_cke2_n | input | 1 | Second mux clock enable, active low |
| seq_wvalid | input | 1 | A write word is presented this cycle |
| seq_wdata | input | DATA_W | Write word |
| seq_rd_cap | input | 1 | Read data is due on dq_in this cycle (baseline timing) |
| dq_in | input | DATA_W | Read data from the bus |
| pin_cs_n | output | NUM_CS | Retimed chip selects |
| pin_ras_n | output | 2 | Two copies of the row strobe |
| pin_cas_n | output | 2 | Two copies of the column strobe |
| pin_we_n | output | 2 | Two copies of the write enable |
| pin_addr0_odd | output | 1 | Address bit 0, odd copy |
| pin_addr0_even | output | 1 | Address bit 0, even copy |
| pin_addr_hi | output | ADDR_W-1 | Address bits ADDR_W-1 down to 1 |
| pin_ba | output | BANK_W | Retimed bank address |
| pin_mux_ckea_n | output | 1 | Retimed mux clock enable (command group) |
| pin_mux_oe_n | output | 1 | Retimed mux output enable |
| pin_mux_sel | output | 1 | Retimed mux select |
| pin_mux_cke1_n | output | 1 | Retimed first mux clock enable |
| pin_mux_cke2_n | output | 1 | Retimed second mux clock enable |
| pin_wdrv | output | 1 | Write data is valid on the bus |
| pin_wdata | output | DATA_W | Write data to the bus |
| rd_valid | output | 1 | Read word available on rd_data |
| rd_data | output | DATA_W | Captured read word |

## Verification
All sixteen configuration settings are applied in turn, each followed by random per-cycle traffic on every group. Because the groups carry independent random values, any stray coupling between one bit and another group's latency shows up as a mismatch. In each setting, a directed burst is also sent: isolated strobes, an all-ones address, a single write word and a single read strobe. These show a one-clock shift without ambiguity and expose a missing or doubled hold cycle. The read checks compare the captured word with dq_in at the expected edge, which separates a delayed strobe from a delayed capture point. A reset applied in the middle of traffic with adjustments active confirms that both register stages return to idle.

// File: rtl/rdimm_rt_pkg.sv
// Package: shared defaults and the mux-control type for the registered-DIMM
// timing adjuster. Assumes nothing beyond standard SystemVerilog.
package rdimm_rt_pkg;

    localparam int unsigned DEF_ADDR_W = 14;  // up to 14 row bits
    localparam int unsigned DEF_BANK_W = 2;   // four internal banks
    localparam int unsigned DEF_NUM_CS = 6;   // six chip-select banks
    localparam int unsigned DEF_DATA_W = 16;  // data word width
    localparam int unsigned PIN_COPIES = 2;   // duplicated strobe outputs

    // Data-path mux control group, delayed as one unit.
    typedef struct packed {
        logic sel;
        logic cke1_n;
        logic cke2_n;
    } mux_ctl_t;

    localparam mux_ctl_t MUX_IDLE = '{sel: 1'b0, cke1_n: 1'b1, cke2_n: 1'b1};

endpackage

// File: rtl/rdimm_rt_delay.sv
// Module: selectable one-or-two register delay line.
// The input is always registered once. When en is high, the output comes
// from a second register instead. Both candidates are flop outputs, so a
// change of en never creates a combinational pulse from the data path.
// Assumes en is static while din is active.
module rdimm_rt_delay #(
    parameter int unsigned     W       = 1,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Shift the input through two register stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= RST_VAL;
            stage2_q <= RST_VAL;
        end else begin
            stage1_q <= din;
            stage2_q <= stage1_q;
        end
    end

    // Pick the baseline or the delayed stage.
    assign dout = en ? stage2_q : stage1_q;

endmodule

// File: rtl/rdimm_rt_wrhold.sv
// Module: write-data window stretcher.
// Registers each write word once. When hold is set, a word that just left
// the first stage is shown for one more cycle from the second stage.
// Assumes the sequencer leaves one idle cycle between words while hold is set.
module rdimm_rt_wrhold #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              wvalid,
    input  logic [DATA_W-1:0] wdata,
    output logic              drv,
    output logic [DATA_W-1:0] dout
);

    logic              v1_q, v2_q;
    logic [DATA_W-1:0] d1_q, d2_q;
    logic              extend;

    // Two-stage history of the write word and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1_q <= 1'b0;
            v2_q <= 1'b0;
            d1_q <= '0;
            d2_q <= '0;
        end else begin
            v1_q <= wvalid;
            d1_q <= wdata;
            v2_q <= v1_q;
            d2_q <= d1_q;
        end
    end

    // The held cycle applies only when no newer word occupies stage one.
    always_comb begin
        extend = hold && v2_q && !v1_q;
        drv    = v1_q || extend;
        dout   = extend ? d2_q : d1_q;
    end

endmodule

// File: rtl/rdimm_rt_rdcap.sv
// Module: read capture point with optional one-clock shift.
// The capture strobe is used directly, or one clock late when adj is set.
// The bus is sampled on the chosen edge, and valid is raised one clock later.
// Assumes adj is static during a read burst.
module rdimm_rt_rdcap #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adj,
    input  logic              cap,
    input  logic [DATA_W-1:0] dq,
    output logic              valid,
    output logic [DATA_W-1:0] data
);

    logic cap_d1_q;
    logic cap_eff;

    // Remember last cycle's capture strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) cap_d1_q <= 1'b0;
        else        cap_d1_q <= cap;
    end

    // Choose the active capture point.
    assign cap_eff = adj ? cap_d1_q : cap;

    // Sample the bus and flag the word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            data  <= '0;
        end else begin
            valid <= cap_eff;
            if (cap_eff) data <= dq;
        end
    end

endmodule

// File: rtl/rdimm_retimer.sv
// Module: registered-DIMM SDRAM timing adjuster (top).
// Retimes sequencer outputs toward the pins. Four static bits each add one
// clock to their own group: command/address, mux control, write window and
// read capture. Assumes configuration changes only while the sequencer idles.
module rdimm_retimer
    import rdimm_rt_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned BANK_W = DEF_BANK_W,
    parameter int unsigned NUM_CS = DEF_NUM_CS,
    parameter int unsigned DATA_W = DEF_DATA_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_rd_adj,
    input  logic                      cfg_mux_adj,
    input  logic                      cfg_wr_hold,
    input  logic                      cfg_cmd_adj,
    input  logic [NUM_CS-1:0]         seq_cs_n,
    input  logic                      seq_ras_n,
    input  logic                      seq_cas_n,
    input  logic                      seq_we_n,
    input  logic [ADDR_W-1:0]         seq_addr,
    input  logic [BANK_W-1:0]         seq_ba,
    input  logic                      seq_mux_ckea_n,
    input  logic                      seq_mux_oe_n,
    input  logic                      seq_mux_sel,
    input  logic                      seq_mux_cke1_n,
    input  logic                      seq_mux_cke2_n,
    input  logic                      seq_wvalid,
    input  logic [DATA_W-1:0]         seq_wdata,
    input  logic                      seq_rd_cap,
    input  logic [DATA_W-1:0]         dq_in,
    output logic [NUM_CS-1:0]         pin_cs_n,
    output logic [PIN_COPIES-1:0]     pin_ras_n,
    output logic [PIN_COPIES-1:0]     pin_cas_n,
    output logic [PIN_COPIES-1:0]     pin_we_n,
    output logic                      pin_addr0_odd,
    output logic                      pin_addr0_even,
    output logic [ADDR_W-1:1]         pin_addr_hi,
    output logic [BANK_W-1:0]         pin_ba,
    output logic                      pin_mux_ckea_n,
    output logic                      pin_mux_oe_n,
    output logic                      pin_mux_sel,
    output logic                      pin_mux_cke1_n,
    output logic                      pin_mux_cke2_n,
    output logic                      pin_wdrv,
    output logic [DATA_W-1:0]         pin_wdata,
    output logic                      rd_valid,
    output logic [DATA_W-1:0]         rd_data
);

    // Command/address group: chip selects, 3 strobes, address, bank, 2 mux lines.
    localparam int unsigned CMD_W = NUM_CS + 3 + ADDR_W + BANK_W + 2;
    localparam logic [CMD_W-1:0] CMD_RST =
        {{NUM_CS{1'b1}}, 3'b111, {ADDR_W{1'b0}}, {BANK_W{1'b0}}, 2'b11};
    localparam int unsigned MUX_W = $bits(mux_ctl_t);

    logic [CMD_W-1:0]  cmd_in, cmd_out;
    logic              ras_q, cas_q, we_q;
    logic [ADDR_W-1:0] addr_q;
    mux_ctl_t          mux_in, mux_out;

    // Gather the command group so one delay keeps it aligned.
    assign cmd_in = {seq_cs_n, seq_ras_n, seq_cas_n, seq_we_n,
                     seq_addr, seq_ba, seq_mux_ckea_n, seq_mux_oe_n};

    rdimm_rt_delay #(
        .W       (CMD_W),
        .RST_VAL (CMD_RST)
    ) u_cmd_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cfg_cmd_adj),
        .din   (cmd_in),
        .dout  (cmd_out)
    );

    // Split the delayed command group back into its fields.
    assign {pin_cs_n, ras_q, cas_q, we_q, addr_q, pin_ba,
            pin_mux_ckea_n, pin_mux_oe_n} = cmd_out;

    // Fan the strobes out to their duplicated pins.
    for (genvar i = 0; i < PIN_COPIES; i++) begin : g_copy
        assign pin_ras_n[i] = ras_q;
        assign pin_cas_n[i] = cas_q;
        assign pin_we_n[i]  = we_q;
    end

    // Address bit 0 drives odd and even copies; the rest go straight out.
    assign pin_addr0_odd  = addr_q[0];
    assign pin_addr0_even = addr_q[0];
    assign pin_addr_hi    = addr_q[ADDR_W-1:1];

    // Mux control group with its own delay.
    assign mux_in = '{sel: seq_mux_sel, cke1_n: seq_mux_cke1_n, cke2_n: seq_mux_cke2_n};

    rdimm_rt_delay #(
        .W       (MUX_W),
        .RST_VAL (MUX_IDLE)
    ) u_mux_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cfg_mux_adj),
        .din   (mux_in),
        .dout  (mux_out)
    );

    assign pin_mux_sel    = mux_out.sel;
    assign pin_mux_cke1_n = mux_out.cke1_n;
    assign pin_mux_cke2_n = mux_out.cke2_n;

    // Write-data window with optional hold cycle.
    rdimm_rt_wrhold #(
        .DATA_W (DATA_W)
    ) u_wr (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (cfg_wr_hold),
        .wvalid (seq_wvalid),
        .wdata  (seq_wdata),
        .drv    (pin_wdrv),
        .dout   (pin_wdata)
    );

    // Read capture point with optional one-clock shift.
    rdimm_rt_rdcap #(
        .DATA_W (DATA_W)
    ) u_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .adj   (cfg_rd_adj),
        .cap   (seq_rd_cap),
        .dq    (dq_in),
        .valid (rd_valid),
        .data  (rd_data)
    );

endmodule

// File: rtl/rdimm_retimer_chk.sv
// Module: property checker for rdimm_retimer, attached by bind.
// Assumes reset is asserted at the first clock edge.
module rdimm_retimer_chk #(
    parameter int unsigned ADDR_W = 14,
    parameter int unsigned NUM_CS = 6,
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_rd_adj,
    input logic              cfg_mux_adj,
    input logic              cfg_wr_hold,
    input logic              cfg_cmd_adj,
    input logic              seq_ras_n,
    input logic [ADDR_W-1:0] seq_addr,
    input logic              seq_mux_sel,
    input logic              seq_wvalid,
    input logic [DATA_W-1:0] seq_wdata,
    input logic              seq_rd_cap,
    input logic [DATA_W-1:0] dq_in,
    input logic [NUM_CS-1:0] pin_cs_n,
    input logic [1:0]        pin_ras_n,
    input logic              pin_addr0_odd,
    input logic [ADDR_W-1:1] pin_addr_hi,
    input logic              pin_mux_oe_n,
    input logic              pin_mux_sel,
    input logic              pin_mux_cke1_n,
    input logic              pin_wdrv,
    input logic [DATA_W-1:0] pin_wdata,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data
);

    logic [1:0] since_rst;
    logic       was_rst;

    // Count cycles since reset, saturating, so history checks stay in range.
    always_ff @(posedge clk) begin
        if (!rst_n)                since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // Outputs are idle one clock after a reset edge.
    always_ff @(posedge clk) begin
        was_rst <= !rst_n;
        if (was_rst === 1'b1) begin
            p_reset_idle_r1: assert (pin_ras_n == 2'b11 && pin_cs_n == '1 &&
                                     pin_mux_oe_n && pin_mux_cke1_n && !pin_mux_sel &&
                                     !pin_wdrv && !rd_valid)
                else $error("R1 outputs not idle after reset");
        end
    end

    p_cmd_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_cmd_adj && since_rst >= 2'd1) |->
            (pin_addr_hi == $past(seq_addr[ADDR_W-1:1]) && pin_ras_n[0] == $past(seq_ras_n)));

    p_cmd_adj_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_cmd_adj && since_rst >= 2'd2) |->
            (pin_addr_hi == $past(seq_addr[ADDR_W-1:1], 2) &&
             pin_addr0_odd == $past(seq_addr[0], 2) &&
             pin_ras_n == {2{$past(seq_ras_n, 2)}}));

    p_mux_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_mux_adj && since_rst >= 2'd1) |-> pin_mux_sel == $past(seq_mux_sel));

    p_mux_adj_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mux_adj && since_rst >= 2'd2) |-> pin_mux_sel == $past(seq_mux_sel, 2));

    p_rd_late_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_rd_adj) && since_rst >= 2'd2) |-> rd_valid == $past(seq_rd_cap, 2));

    p_rd_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cfg_rd_adj) && since_rst >= 2'd1) |-> rd_valid == $past(seq_rd_cap));

    p_rd_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && since_rst >= 2'd1) |-> rd_data == $past(dq_in));

    p_wr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_hold && since_rst >= 2'd2 && $past(seq_wvalid, 2) && !$past(seq_wvalid)) |->
            (pin_wdrv && pin_wdata == $past(seq_wdata, 2)));

    p_wr_base_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr_hold && since_rst >= 2'd1) |-> pin_wdrv == $past(seq_wvalid));

endmodule

bind rdimm_retimer rdimm_retimer_chk #(
    .ADDR_W (ADDR_W),
    .NUM_CS (NUM_CS),
    .DATA_W (DATA_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_rd_adj     (cfg_rd_adj),
    .cfg_mux_adj    (cfg_mux_adj),
    .cfg_wr_hold    (cfg_wr_hold),
    .cfg_cmd_adj    (cfg_cmd_adj),
    .seq_ras_n      (seq_ras_n),
    .seq_addr       (seq_addr),
    .seq_mux_sel    (seq_mux_sel),
    .seq_wvalid     (seq_wvalid),
    .seq_wdata      (seq_wdata),
    .seq_rd_cap     (seq_rd_cap),
    .dq_in          (dq_in),
    .pin_cs_n       (pin_cs_n),
    .pin_ras_n      (pin_ras_n),
    .pin_addr0_odd  (pin_addr0_odd),
    .pin_addr_hi    (pin_addr_hi),
    .pin_mux_oe_n   (pin_mux_oe_n),
    .pin_mux_sel    (pin_mux_sel),
    .pin_mux_cke1_n (pin_mux_cke1_n),
    .pin_wdrv       (pin_wdrv),
    .pin_wdata      (pin_wdata),
    .rd_valid       (rd_valid),
    .rd_data        (rd_data)
);

// File: tb/rdimm_retimer_tb.sv
// Bench: sweeps all sixteen configuration settings with random and directed
// traffic, and predicts each output group from a two-cycle input history.
module rdimm_retimer_tb;

    localparam int CLK_PERIOD = 8;
    localparam int AW = 14;
    localparam int BW = 2;
    localparam int NCS = 6;
    localparam int DW = 16;
    localparam int RAND_CYCLES = 150;

    typedef struct {
        logic [3:0]     cfg;   // {rd, mux, wr, cmd}
        logic [NCS-1:0] cs_n;
        logic           ras_n, cas_n, we_n;
        logic [AW-1:0]  addr;
        logic [BW-1:0]  ba;
        logic           ckea_n, oe_n;
        logic           sel, cke1_n, cke2_n;
        logic           wv;
        logic [DW-1:0]  wd;
        logic           cap;
        logic [DW-1:0]  dq;
    } stim_t;

    logic clk = 1'b0;
    logic rst_n;
    logic cfg_rd_adj, cfg_mux_adj, cfg_wr_hold, cfg_cmd_adj;
    logic [NCS-1:0] seq_cs_n;
    logic seq_ras_n, seq_cas_n, seq_we_n;
    logic [AW-1:0] seq_addr;
    logic [BW-1:0] seq_ba;
    logic seq_mux_ckea_n, seq_mux_oe_n, seq_mux_sel, seq_mux_cke1_n, seq_mux_cke2_n;
    logic seq_wvalid, seq_rd_cap;
    logic [DW-1:0] seq_wdata, dq_in;
    logic [NCS-1:0] pin_cs_n;
    logic [1:0] pin_ras_n, pin_cas_n, pin_we_n;
    logic pin_addr0_odd, pin_addr0_even;
    logic [AW-1:1] pin_addr_hi;
    logic [BW-1:0] pin_ba;
    logic pin_mux_ckea_n, pin_mux_oe_n, pin_mux_sel, pin_mux_cke1_n, pin_mux_cke2_n;
    logic pin_wdrv, rd_valid;
    logic [DW-1:0] pin_wdata, rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    stim_t h0, h1;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rdimm_retimer #(.ADDR_W(AW), .BANK_W(BW), .NUM_CS(NCS), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_rd_adj(cfg_rd_adj), .cfg_mux_adj(cfg_mux_adj),
        .cfg_wr_hold(cfg_wr_hold), .cfg_cmd_adj(cfg_cmd_adj),
        .seq_cs_n(seq_cs_n), .seq_ras_n(seq_ras_n), .seq_cas_n(seq_cas_n),
        .seq_we_n(seq_we_n), .seq_addr(seq_addr), .seq_ba(seq_ba),
        .seq_mux_ckea_n(seq_mux_ckea_n), .seq_mux_oe_n(seq_mux_oe_n),
        .seq_mux_sel(seq_mux_sel), .seq_mux_cke1_n(seq_mux_cke1_n),
        .seq_mux_cke2_n(seq_mux_cke2_n), .seq_wvalid(seq_wvalid),
        .seq_wdata(seq_wdata), .seq_rd_cap(seq_rd_cap), .dq_in(dq_in),
        .pin_cs_n(pin_cs_n), .pin_ras_n(pin_ras_n), .pin_cas_n(pin_cas_n),
        .pin_we_n(pin_we_n), .pin_addr0_odd(pin_addr0_odd),
        .pin_addr0_even(pin_addr0_even), .pin_addr_hi(pin_addr_hi),
        .pin_ba(pin_ba), .pin_mux_ckea_n(pin_mux_ckea_n),
        .pin_mux_oe_n(pin_mux_oe_n), .pin_mux_sel(pin_mux_sel),
        .pin_mux_cke1_n(pin_mux_cke1_n), .pin_mux_cke2_n(pin_mux_cke2_n),
        .pin_wdrv(pin_wdrv), .pin_wdata(pin_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    function automatic stim_t idle_stim(input logic [3:0] cfg);
        stim_t s;
        s.cfg = cfg; s.cs_n = '1; s.ras_n = 1'b1; s.cas_n = 1'b1; s.we_n = 1'b1;
        s.addr = '0; s.ba = '0; s.ckea_n = 1'b1; s.oe_n = 1'b1;
        s.sel = 1'b0; s.cke1_n = 1'b1; s.cke2_n = 1'b1;
        s.wv = 1'b0; s.wd = '0; s.cap = 1'b0; s.dq = '0;
        return s;
    endfunction

    function automatic stim_t rand_stim(input logic [3:0] cfg, input logic prev_wv);
        stim_t s;
        s.cfg = cfg;
        s.cs_n = NCS'($urandom); s.ras_n = 1'($urandom); s.cas_n = 1'($urandom);
        s.we_n = 1'($urandom); s.addr = AW'($urandom); s.ba = BW'($urandom);
        s.ckea_n = 1'($urandom); s.oe_n = 1'($urandom); s.sel = 1'($urandom);
        s.cke1_n = 1'($urandom); s.cke2_n = 1'($urandom);
        s.wv = (($urandom % 3) == 0) && !(cfg[1] && prev_wv);
        s.wd = DW'($urandom); s.cap = (($urandom % 3) == 0); s.dq = DW'($urandom);
        return s;
    endfunction

    function automatic logic [NCS+3+AW+BW+1:0] pack_cmd(input stim_t s);
        return {s.cs_n, s.ras_n, s.cas_n, s.we_n, s.addr, s.ba, s.ckea_n, s.oe_n};
    endfunction

    task automatic apply(input stim_t s);
        {cfg_rd_adj, cfg_mux_adj, cfg_wr_hold, cfg_cmd_adj} = s.cfg;
        seq_cs_n = s.cs_n; seq_ras_n = s.ras_n; seq_cas_n = s.cas_n; seq_we_n = s.we_n;
        seq_addr = s.addr; seq_ba = s.ba; seq_mux_ckea_n = s.ckea_n; seq_mux_oe_n = s.oe_n;
        seq_mux_sel = s.sel; seq_mux_cke1_n = s.cke1_n; seq_mux_cke2_n = s.cke2_n;
        seq_wvalid = s.wv; seq_wdata = s.wd; seq_rd_cap = s.cap; dq_in = s.dq;
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cfg=%b act=%0h exp=%0h", tag, h0.cfg, act, exp);
        end
    endtask

    // R1: everything idle after a reset edge
    task automatic check_reset();
        chk("R1 cmd group idle",
            64'({pin_cs_n, pin_ras_n, pin_cas_n, pin_we_n, pin_mux_ckea_n, pin_mux_oe_n}),
            64'({{NCS{1'b1}}, 6'b111111, 2'b11}));
        chk("R1 mux group idle", 64'({pin_mux_sel, pin_mux_cke1_n, pin_mux_cke2_n}), 64'(3'b011));
        chk("R1 write and read idle", 64'({pin_wdrv, rd_valid}), 64'(2'b00));
    endtask

    task automatic check_all();
        stim_t c, sc, sm;
        logic exp_drv, exp_rv;
        logic [DW-1:0] exp_wd;
        c  = h0;
        sc = c.cfg[0] ? h1 : h0;
        sm = c.cfg[2] ? h1 : h0;
        chk(c.cfg[0] ? "R3 R8 cmd group two clocks" : "R2 R8 cmd group one clock",
            64'({pin_cs_n, pin_ras_n[0], pin_cas_n[0], pin_we_n[0], pin_addr_hi,
                 pin_addr0_even, pin_ba, pin_mux_ckea_n, pin_mux_oe_n}),
            64'(pack_cmd(sc)));
        chk("R9 duplicated pins",
            64'({pin_ras_n, pin_cas_n, pin_we_n, pin_addr0_odd, pin_addr0_even}),
            64'({{2{sc.ras_n}}, {2{sc.cas_n}}, {2{sc.we_n}}, sc.addr[0], sc.addr[0]}));
        chk(c.cfg[2] ? "R4 R8 mux group two clocks" : "R2 R8 mux group one clock",
            64'({pin_mux_sel, pin_mux_cke1_n, pin_mux_cke2_n}),
            64'({sm.sel, sm.cke1_n, sm.cke2_n}));
        exp_drv = h0.wv || (c.cfg[1] && h1.wv);
        exp_wd  = h0.wv ? h0.wd : h1.wd;
        chk(c.cfg[1] ? "R6 R8 write drive held" : "R7 R8 write drive", 64'(pin_wdrv), 64'(exp_drv));
        if (exp_drv) chk(c.cfg[1] ? "R6 write word" : "R7 write word", 64'(pin_wdata), 64'(exp_wd));
        exp_rv = c.cfg[3] ? h1.cap : h0.cap;
        chk("R5 R8 read valid latency", 64'(rd_valid), 64'(exp_rv));
        if (exp_rv) chk("R5 read capture word", 64'(rd_data), 64'(h0.dq));
    endtask

    task automatic cycle(input stim_t s);
        @(negedge clk);
        check_all();
        apply(s);
        h1 = h0;
        h0 = s;
    endtask

    initial begin
        stim_t s;
        void'($urandom(32'd20011));
        rst_n = 1'b0;
        s = idle_stim(4'b0000);
        apply(s);
        h0 = s; h1 = s;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset();
        rst_n = 1'b1;
        for (int cfg = 0; cfg < 16; cfg++) begin
            // idle twice, then switch configuration while idle
            cycle(idle_stim(h0.cfg));
            cycle(idle_stim(h0.cfg));
            cycle(idle_stim(4'(cfg)));
            cycle(idle_stim(4'(cfg)));
            // directed burst: isolated strobes, all-ones address, one write, one read
            s = idle_stim(4'(cfg));
            s.ras_n = 1'b0; s.cs_n[0] = 1'b0; s.addr = '1; s.ba = '1;
            s.sel = 1'b1; s.cke1_n = 1'b0; s.oe_n = 1'b0;
            s.wv = 1'b1; s.wd = 16'hA5C3; s.cap = 1'b1; s.dq = 16'h3C5A;
            cycle(s);
            s = idle_stim(4'(cfg)); s.dq = 16'h7E81;
            cycle(s);
            for (int k = 0; k < 3; k++) cycle(idle_stim(4'(cfg)));
            for (int k = 0; k < RAND_CYCLES; k++) cycle(rand_stim(4'(cfg), h0.wv));
            for (int k = 0; k < 2; k++) cycle(idle_stim(4'(cfg)));
        end
        // R1: reset in the middle of traffic with every adjustment active
        cycle(idle_stim(4'b1111));
        cycle(rand_stim(4'b1111, 1'b0));
        cycle(rand_stim(4'b1111, 1'b0));
        @(negedge clk);
        check_all();
        rst_n = 1'b0;
        apply(rand_stim(4'b1111, 1'b0));
        @(negedge clk);
        check_reset();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule